// File: doc/BRIEF.md
# SD Host Command-Issue Inhibit Tracker

This block decides whether an SD/MMC host controller may start a new command. It keeps two flags: a command-line inhibit, which covers the time from the command-register write until the response arrives, and a data-line inhibit, which covers data activity, read transfers, read wait and busy-signalling responses. When either flag falls, the block raises the matching completion interrupt status bit. Software clears these bits by writing one to them.

Software (or the register front end) presents a candidate command index on `query_idx` and reads `issue_ok`. A small group of indices (0, 12, 13 and 52) may go out while the data lines are busy. All other indices need both flags clear. A command-register write that the flags do not allow is rejected. A rejected write leaves both flags as they were and sets a sticky issue-error status bit.

The command side is a three-state machine. C_IDLE moves to C_WAIT on an accepted write. C_WAIT moves to C_IDLE when a response is received, which is the command-complete transition. C_WAIT moves to C_HALT when a conflict error or an auto-stop error arrives, which is the error-hold transition. C_HALT moves back to C_WAIT when a recovery write is accepted. The data side is a three-state machine as well. D_FREE moves to D_HELD when any data-line level is active. Either state moves to D_BUSY when a busy-response command is accepted. D_BUSY moves to D_HELD or D_FREE when the busy signal is released. D_HELD moves to D_FREE when all levels are idle, which is the transfer-complete transition.

Top module: `cmd_issue_tracker`

## Requirements
- R1: After reset, `cmd_inhibit` and `dat_inhibit` are 0 and all three `irq_status` bits are 0.
- R2: An accepted command write (`cmd_wr` high with the flags permitting `cmd_idx`) makes `cmd_inhibit` 1 at the clock edge that samples the write.
- R3: A `rsp_done` strobe while waiting for a response clears `cmd_inhibit`. At the same edge it sets `irq_status[0]` (command complete).
- R4: A `conflict_err` or `autostop_err` strobe while waiting for a response keeps `cmd_inhibit` at 1 and does not set `irq_status[0]`. The error wins over a `rsp_done` in the same cycle, and later `rsp_done` strobes are ignored. An auto-stop error leaves `dat_inhibit` unchanged.
- R5: In the error-hold state, a command write that the data-line rule permits is accepted as recovery. It raises no issue error. A following `rsp_done` clears `cmd_inhibit` and sets `irq_status[0]`.
- R6: `dat_inhibit` equals the OR of `dat_active`, `rd_xfer_active` and `rd_wait`, sampled one edge earlier, whenever no busy hold is pending.
- R7: A falling edge of `dat_inhibit` sets `irq_status[1]` (transfer complete) at the same edge.
- R8: An accepted write with `rsp_type` = 2'b11 (response with busy) sets `dat_inhibit` at that edge. `dat_inhibit` then stays 1 until the edge that samples `busy_release`. The other codes are 2'b00 (none), 2'b01 (short) and 2'b10 (long), and none of them holds the data lines.
- R9: `issue_ok` is 1 exactly when `cmd_inhibit` is 0 and either `dat_inhibit` is 0 or `query_idx` is one of 0, 12, 13, 52.
- R10: A command write that is not permitted sets `irq_status[2]` (issue error, sticky) and leaves `cmd_inhibit` and `dat_inhibit` unchanged.
- R11: `irq_clr_wr` with `irq_clr_data[i]` = 1 clears `irq_status[i]`. A set event for the same bit in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_idx | input | 6 | Index of the command being written |
| rsp_type | input | 2 | Response kind of the written command (11 = with busy) |
| rsp_done | input | 1 | Command response received strobe |
| conflict_err | input | 1 | Command conflict error strobe |
| autostop_err | input | 1 | Auto stop command not issued due to error |
| dat_active | input | 1 | Data lines active (level) |
| rd_xfer_active | input | 1 | Read transfer active (level) |
| rd_wait | input | 1 | Read wait asserted (level) |
| busy_release | input | 1 | Card busy signal released strobe |
| query_idx | input | 6 | Command index whose issue permission is asked |
| irq_clr_wr | input | 1 | Write strobe for the interrupt status clear |
| irq_clr_data | input | 3 | Write-one-to-clear mask for `irq_status` |
| cmd_inhibit | output | 1 | Command-line inhibit flag |
| dat_inhibit | output | 1 | Data-line inhibit flag |
| issue_ok | output | 1 | `query_idx` may be issued now |
| irq_status | output | 3 | [0] command complete, [1] transfer complete, [2] issue error |

## Verification
The assertions assume that `rsp_done`, `conflict_err` and `autostop_err` are single-cycle strobes. They also assume that the error strobes and `busy_release` arrive only while the matching wait is in progress, and that the data-line levels hold steady for at least one cycle. The bench drives every strobe for exactly one cycle, away from the clock edge. It raises errors only after an accepted command, and it pulses `busy_release` only after a busy-response command. Exhaustive sweeps of all 64 indices, for both queries and writes, keep the exemption set fully covered without violating these assumptions.

// File: rtl/cit_pkg.sv
package cit_pkg;
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_WAIT = 2'd1,
        C_HALT = 2'd2
    } cmd_st_e;

    typedef enum logic [1:0] {
        D_FREE = 2'd0,
        D_HELD = 2'd1,
        D_BUSY = 2'd2
    } dat_st_e;

    localparam logic [1:0] RSP_WITH_BUSY = 2'b11;

    localparam int IRQ_CC = 0;
    localparam int IRQ_TC = 1;
    localparam int IRQ_IE = 2;
    localparam int IRQ_N  = 3;
endpackage

// File: rtl/cit_permit.sv
module cit_permit #(
    parameter int IDX_W = 6,
    parameter logic [(1<<IDX_W)-1:0] EXEMPT_MASK = '0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             cmd_free,
    input  logic             dat_free,
    output logic             ok
);
    logic exempt;

    always_comb begin
        exempt = EXEMPT_MASK[idx];
        ok     = cmd_free && (dat_free || exempt);
    end
endmodule

// File: rtl/cit_cmd_fsm.sv
module cit_cmd_fsm
    import cit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic rsp_done,
    input  logic conflict_err,
    input  logic autostop_err,
    output logic inhibit,
    output logic can_take,
    output logic done_evt
);
    cmd_st_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            C_IDLE: if (accept) nxt = C_WAIT;
            C_WAIT: begin
                if (conflict_err || autostop_err) nxt = C_HALT;
                else if (rsp_done)                nxt = C_IDLE;
            end
            C_HALT: if (accept) nxt = C_WAIT;
            default: nxt = C_IDLE;
        endcase
    end

    always_comb begin
        inhibit  = (state != C_IDLE);
        can_take = (state != C_WAIT);
        done_evt = (state == C_WAIT) && (nxt == C_IDLE);
    end
endmodule

// File: rtl/cit_dat_fsm.sv
module cit_dat_fsm
    import cit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lines_busy,
    input  logic busy_start,
    input  logic busy_release,
    output logic inhibit,
    output logic done_evt
);
    dat_st_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= D_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            D_FREE: begin
                if (busy_start)      nxt = D_BUSY;
                else if (lines_busy) nxt = D_HELD;
            end
            D_HELD: begin
                if (busy_start)       nxt = D_BUSY;
                else if (!lines_busy) nxt = D_FREE;
            end
            D_BUSY: begin
                if (busy_start)        nxt = D_BUSY;
                else if (busy_release) nxt = lines_busy ? D_HELD : D_FREE;
            end
            default: nxt = D_FREE;
        endcase
    end

    always_comb begin
        inhibit  = (state != D_FREE);
        done_evt = (state != D_FREE) && (nxt == D_FREE);
    end
endmodule

// File: rtl/cit_irq_w1c.sv
module cit_irq_w1c #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                      status[i] <= 1'b0;
            else if (set_evt[i])             status[i] <= 1'b1;
            else if (clr_wr && clr_data[i])  status[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_issue_tracker.sv
module cmd_issue_tracker
    import cit_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter logic [(1<<IDX_W)-1:0] EXEMPT_MASK =
        ((1<<IDX_W)'(1) << 0)  | ((1<<IDX_W)'(1) << 12) |
        ((1<<IDX_W)'(1) << 13) | ((1<<IDX_W)'(1) << 52)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [1:0]       rsp_type,
    input  logic             rsp_done,
    input  logic             conflict_err,
    input  logic             autostop_err,
    input  logic             dat_active,
    input  logic             rd_xfer_active,
    input  logic             rd_wait,
    input  logic             busy_release,
    input  logic [IDX_W-1:0] query_idx,
    input  logic             irq_clr_wr,
    input  logic [2:0]       irq_clr_data,
    output logic             cmd_inhibit,
    output logic             dat_inhibit,
    output logic             issue_ok,
    output logic [2:0]       irq_status
);
    logic can_take, wr_ok, accept, reject;
    logic cmd_done, dat_done, busy_start, lines_busy;
    logic [IRQ_N-1:0] set_evt;

    cit_permit #(.IDX_W(IDX_W), .EXEMPT_MASK(EXEMPT_MASK)) u_query (
        .idx      (query_idx),
        .cmd_free (!cmd_inhibit),
        .dat_free (!dat_inhibit),
        .ok       (issue_ok)
    );

    cit_permit #(.IDX_W(IDX_W), .EXEMPT_MASK(EXEMPT_MASK)) u_write (
        .idx      (cmd_idx),
        .cmd_free (can_take),
        .dat_free (!dat_inhibit),
        .ok       (wr_ok)
    );

    always_comb begin
        accept     = cmd_wr && wr_ok;
        reject     = cmd_wr && !wr_ok;
        busy_start = accept && (rsp_type == RSP_WITH_BUSY);
        lines_busy = dat_active || rd_xfer_active || rd_wait;
        set_evt            = '0;
        set_evt[IRQ_CC]    = cmd_done;
        set_evt[IRQ_TC]    = dat_done;
        set_evt[IRQ_IE]    = reject;
    end

    cit_cmd_fsm u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .rsp_done     (rsp_done),
        .conflict_err (conflict_err),
        .autostop_err (autostop_err),
        .inhibit      (cmd_inhibit),
        .can_take     (can_take),
        .done_evt     (cmd_done)
    );

    cit_dat_fsm u_dat (
        .clk          (clk),
        .rst_n        (rst_n),
        .lines_busy   (lines_busy),
        .busy_start   (busy_start),
        .busy_release (busy_release),
        .inhibit      (dat_inhibit),
        .done_evt     (dat_done)
    );

    cit_irq_w1c #(.N(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .clr_wr   (irq_clr_wr),
        .clr_data (irq_clr_data),
        .status   (irq_status)
    );
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [IDX_W-1:0] cmd_idx,
    input logic             rsp_done,
    input logic             conflict_err,
    input logic             autostop_err,
    input logic             dat_active,
    input logic             rd_xfer_active,
    input logic             rd_wait,
    input logic             cmd_inhibit,
    input logic             dat_inhibit,
    input logic             issue_ok,
    input logic [2:0]       irq_status
);
    // R2: write from idle with free data lines starts the command
    a_r2_write_sets_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_inhibit && !dat_inhibit) |=> cmd_inhibit);

    // R3: command inhibit falling implies command-complete status
    a_r3_fall_sets_cc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_inhibit) |-> irq_status[0]);

    // R4: error while waiting keeps the inhibit high
    a_r4_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inhibit && (conflict_err || autostop_err)) |=> cmd_inhibit);

    // R6: any data-line level raises the data inhibit next edge
    a_r6_levels_hold_dat: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_active || rd_xfer_active || rd_wait) |=> dat_inhibit);

    // R7: data inhibit falling implies transfer-complete status
    a_r7_fall_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_inhibit) |-> irq_status[1]);

    // R9: permission never granted during command-line inhibit
    a_r9_ok_needs_cmd_free: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> !cmd_inhibit);

    // R10: a non-exempt index written while the data lines are held is refused
    a_r10_reject_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_inhibit && dat_inhibit && cmd_idx == IDX_W'(17))
        |=> (irq_status[2] && !cmd_inhibit));
endmodule

bind cmd_issue_tracker cit_checker #(.IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_wr         (cmd_wr),
    .cmd_idx        (cmd_idx),
    .rsp_done       (rsp_done),
    .conflict_err   (conflict_err),
    .autostop_err   (autostop_err),
    .dat_active     (dat_active),
    .rd_xfer_active (rd_xfer_active),
    .rd_wait        (rd_wait),
    .cmd_inhibit    (cmd_inhibit),
    .dat_inhibit    (dat_inhibit),
    .issue_ok       (issue_ok),
    .irq_status     (irq_status)
);

// File: tb/sim_cmd_issue_tracker.sv
`timescale 1ns/1ps
module sim_cmd_issue_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [5:0] cmd_idx = '0;
    logic [1:0] rsp_type = 2'b01;
    logic       rsp_done = 1'b0;
    logic       conflict_err = 1'b0;
    logic       autostop_err = 1'b0;
    logic       dat_active = 1'b0;
    logic       rd_xfer_active = 1'b0;
    logic       rd_wait = 1'b0;
    logic       busy_release = 1'b0;
    logic [5:0] query_idx = '0;
    logic       irq_clr_wr = 1'b0;
    logic [2:0] irq_clr_data = '0;
    logic       cmd_inhibit, dat_inhibit, issue_ok;
    logic [2:0] irq_status;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmd_issue_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx),
        .rsp_type(rsp_type), .rsp_done(rsp_done), .conflict_err(conflict_err),
        .autostop_err(autostop_err), .dat_active(dat_active),
        .rd_xfer_active(rd_xfer_active), .rd_wait(rd_wait),
        .busy_release(busy_release), .query_idx(query_idx),
        .irq_clr_wr(irq_clr_wr), .irq_clr_data(irq_clr_data),
        .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
        .issue_ok(issue_ok), .irq_status(irq_status)
    );

    function automatic bit is_exempt(int i);
        return (i == 0) || (i == 12) || (i == 13) || (i == 52);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cmd_wr = 1'b0; rsp_done = 1'b0; conflict_err = 1'b0;
        autostop_err = 1'b0; busy_release = 1'b0;
        irq_clr_wr = 1'b0; irq_clr_data = '0;
    endtask

    task automatic write_cmd(int idx, logic [1:0] kind);
        cmd_idx = 6'(idx); rsp_type = kind; cmd_wr = 1'b1;
        step();
    endtask

    task automatic respond();
        rsp_done = 1'b1;
        step();
    endtask

    task automatic clear_irq(logic [2:0] m);
        irq_clr_wr = 1'b1; irq_clr_data = m;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 cmd_inhibit", cmd_inhibit, 0);
        check("R1 dat_inhibit", dat_inhibit, 0);
        check("R1 irq_status", irq_status, 0);
        rst_n = 1'b1;
        step();
        check("R1 after release", {cmd_inhibit, dat_inhibit, irq_status}, 0);

        // R2 / R3 basic command round trip
        write_cmd(17, 2'b01);
        check("R2 inhibit set", cmd_inhibit, 1);
        check("R2 no cc yet", irq_status[0], 0);
        check("R8 short rsp no dat hold", dat_inhibit, 0);
        respond();
        check("R3 inhibit clear", cmd_inhibit, 0);
        check("R3 cc set", irq_status[0], 1);

        // R11 clear and set-priority
        clear_irq(3'b001);
        check("R11 cc cleared", irq_status[0], 0);
        write_cmd(8, 2'b10);
        rsp_done = 1'b1; irq_clr_wr = 1'b1; irq_clr_data = 3'b001;
        step();
        check("R11 set wins", irq_status[0], 1);
        clear_irq(3'b001);

        // R6 / R7 all level combinations
        for (int c = 1; c < 8; c++) begin
            dat_active = c[0]; rd_xfer_active = c[1]; rd_wait = c[2];
            step();
            check("R6 levels", dat_inhibit, 1);
            dat_active = 0; rd_xfer_active = 0; rd_wait = 0;
            step();
            check("R6 idle", dat_inhibit, 0);
            check("R7 tc set", irq_status[1], 1);
            clear_irq(3'b010);
            check("R11 tc cleared", irq_status[1], 0);
        end

        // R9 query sweep, data held and free
        rd_wait = 1'b1;
        step();
        for (int i = 0; i < 64; i++) begin
            query_idx = 6'(i); #1;
            check("R9 data held", issue_ok, int'(is_exempt(i)));
        end
        rd_wait = 1'b0;
        step();
        clear_irq(3'b010);
        for (int i = 0; i < 64; i++) begin
            query_idx = 6'(i); #1;
            check("R9 all free", issue_ok, 1);
        end
        write_cmd(3, 2'b01);
        for (int i = 0; i < 64; i += 13) begin
            query_idx = 6'(i); #1;
            check("R9 cmd held", issue_ok, 0);
        end
        // R10 write while waiting for response
        write_cmd(0, 2'b01);
        check("R10 err while waiting", irq_status[2], 1);
        check("R10 cmd unchanged", cmd_inhibit, 1);
        clear_irq(3'b100);
        respond();
        clear_irq(3'b001);

        // R10 / R2 write sweep with data lines held
        rd_xfer_active = 1'b1;
        step();
        for (int i = 0; i < 64; i++) begin
            write_cmd(i, 2'b01);
            check("R2 exempt accepted", cmd_inhibit, int'(is_exempt(i)));
            check("R10 err flag", irq_status[2], int'(!is_exempt(i)));
            check("R10 dat unchanged", dat_inhibit, 1);
            if (is_exempt(i)) begin
                respond();
                clear_irq(3'b001);
            end else begin
                clear_irq(3'b100);
            end
        end
        rd_xfer_active = 1'b0;
        step();
        clear_irq(3'b010);

        // R8 busy-response hold
        write_cmd(7, 2'b11);
        check("R8 dat held at accept", dat_inhibit, 1);
        respond();
        check("R8 cmd clear", cmd_inhibit, 0);
        step(); step(); step();
        check("R8 still held", dat_inhibit, 1);
        check("R8 no tc", irq_status[1], 0);
        busy_release = 1'b1;
        step();
        check("R8 released", dat_inhibit, 0);
        check("R7 tc after busy", irq_status[1], 1);
        clear_irq(3'b011);

        // R4 conflict error beats response
        write_cmd(17, 2'b01);
        conflict_err = 1'b1; rsp_done = 1'b1;
        step();
        check("R4 held", cmd_inhibit, 1);
        check("R4 no cc", irq_status[0], 0);
        respond();
        check("R4 rsp ignored", cmd_inhibit, 0 + 1);
        check("R4 still no cc", irq_status[0], 0);
        // R5 recovery
        write_cmd(18, 2'b01);
        check("R5 no err", irq_status[2], 0);
        check("R5 still inhibited", cmd_inhibit, 1);
        respond();
        check("R5 cleared", cmd_inhibit, 0);
        check("R5 cc", irq_status[0], 1);
        clear_irq(3'b001);

        // R4 auto-stop error with read transfer running
        rd_xfer_active = 1'b1;
        step();
        write_cmd(12, 2'b01);
        autostop_err = 1'b1;
        step();
        check("R4 autostop held", cmd_inhibit, 1);
        check("R4 autostop dat", dat_inhibit, 1);
        rd_xfer_active = 1'b0;
        step();
        check("R4 dat unaffected", dat_inhibit, 0);
        check("R4 autostop no cc", irq_status[0], 0);
        write_cmd(13, 2'b01);
        respond();
        check("R5 recovery cc", irq_status[0], 1);
        check("R5 recovery clear", cmd_inhibit, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule